// File: doc/BRIEF.md
# Flash Block Lock Manager

This block decides whether a program or erase request may touch a given erase block of a flash array. A command port delivers decoded lock commands, each made of an 8-bit opcode and a block address. From these the block keeps three pieces of state: a global lock flag, one inclusive unlocked address window, and a lock-tight latch. Once the latch is set, the lock state is frozen until reset.

Every program or erase request presents its target block. One cycle later the block returns a verdict. A request aimed at a locked block is refused and sets a sticky interrupt flag. Software clears that flag with a write-1-to-clear pulse. An unlock takes two commands: the first loads the start address and the second supplies the end address and commits the window.

Top module: `flash_lock_mgr`

## Requirements
- R1: Out of reset every block is writable, lock-tight is clear, the interrupt flag is 0 and no response is valid.
- R2: A request presented in cycle N gives `resp_valid`=1 in cycle N+1, with `resp_ok` evaluated against the lock state held before any command accepted in cycle N.
- R3: Opcode 0x21 sets the global lock and discards the unlock window, whatever block address it carries.
- R4: Opcode 0x10 latches a pending start address S. A following opcode 0x11 with end address E, where S < E, makes blocks S..E (inclusive) writable while the global lock is set; all other blocks stay locked.
- R5: An 0x10/0x11 pair with S >= E is discarded: the previous window and lock flag are kept, and the pending start is consumed.
- R6: An 0x11 command with no pending 0x10 start (after reset or after an earlier 0x11) has no effect.
- R7: Opcode 0x31 sets lock-tight. While it is set, commands 0x10, 0x11, 0x21 and 0x31 change nothing. Only reset clears it.
- R8: A request to a locked block returns `resp_ok`=0 and sets `irq_locked`. The flag stays 1 until an `irq_clr` pulse clears it, and a new locked request in the same cycle as `irq_clr` keeps it set. A request to a writable block leaves the flag unchanged.
- R9: Opcodes other than 0x10, 0x11, 0x21 and 0x31 leave the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 8 | Lock command opcode |
| cmd_blk | input | BLK_W | Block address of the command |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | BLK_W | Target block of the request |
| irq_clr | input | 1 | Write-1-to-clear pulse for the interrupt flag |
| resp_valid | output | 1 | Verdict valid, one cycle after the request |
| resp_ok | output | 1 | 1 = request allowed, 0 = refused |
| irq_locked | output | 1 | Sticky flag for a refused request |

## Verification
The hardest case to reach is the frozen state under lock-tight with a partial window already in force. To get there, the stimulus first locks the array, then commits a window, then sets the latch. It then sends lock-all and full-range unlocks that must not change the window, and probes every block. The unlock path is swept over every start/end pair of a 16-block configuration, including equal and reversed pairs, with a full probe of all blocks after each pair. A request and a lock command are also issued in the same cycle to pin down which state the verdict is taken from.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  typedef enum logic [7:0] {
    OP_RANGE_START = 8'h10,
    OP_RANGE_END   = 8'h11,
    OP_LOCK_ALL    = 8'h21,
    OP_LOCK_TIGHT  = 8'h31
  } lock_op_e;

endpackage

// File: rtl/flash_lock_state.sv
module flash_lock_state
  import flash_lock_pkg::*;
#(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  output logic             glock,
  output logic             tight,
  output logic             win_vld,
  output logic [BLK_W-1:0] win_lo,
  output logic [BLK_W-1:0] win_hi
);

  logic             pend_q;
  logic [BLK_W-1:0] start_q;
  logic             accept;

  // commands are dropped entirely once the tight latch is set
  assign accept = cmd_valid && !tight;

  always_ff @(posedge clk) begin
    if (rst) begin
      glock   <= 1'b0;
      tight   <= 1'b0;
      win_vld <= 1'b0;
      win_lo  <= '0;
      win_hi  <= '0;
      pend_q  <= 1'b0;
      start_q <= '0;
    end else if (accept) begin
      case (cmd_op)
        OP_RANGE_START: begin
          start_q <= cmd_blk;
          pend_q  <= 1'b1;
        end
        OP_RANGE_END: begin
          pend_q <= 1'b0;
          if (pend_q && (start_q < cmd_blk)) begin
            win_lo  <= start_q;
            win_hi  <= cmd_blk;
            win_vld <= 1'b1;
          end
        end
        OP_LOCK_ALL: begin
          glock   <= 1'b1;
          win_vld <= 1'b0;
        end
        OP_LOCK_TIGHT: begin
          tight <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_lock_window.sv
module flash_lock_window #(
  parameter int BLK_W = 10
) (
  input  logic [BLK_W-1:0] blk,
  input  logic             glock,
  input  logic             win_vld,
  input  logic [BLK_W-1:0] win_lo,
  input  logic [BLK_W-1:0] win_hi,
  output logic             writable
);

  logic above_lo;
  logic below_hi;

  assign above_lo = (blk >= win_lo);
  assign below_hi = (blk <= win_hi);
  assign writable = !glock || (win_vld && above_lo && below_hi);

endmodule

// File: rtl/flash_lock_resp.sv
module flash_lock_resp (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic writable,
  input  logic irq_clr,
  output logic resp_valid,
  output logic resp_ok,
  output logic irq_locked
);

  logic refuse;

  assign refuse = req_valid && !writable;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      irq_locked <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= req_valid && writable;
      // a new refusal has priority over the clear pulse
      if (refuse)
        irq_locked <= 1'b1;
      else if (irq_clr)
        irq_locked <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr #(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             irq_clr,
  output logic             resp_valid,
  output logic             resp_ok,
  output logic             irq_locked
);

  logic             glock;
  logic             tight;
  logic             win_vld;
  logic [BLK_W-1:0] win_lo;
  logic [BLK_W-1:0] win_hi;
  logic             writable;

  flash_lock_state #(.BLK_W(BLK_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_blk   (cmd_blk),
    .glock     (glock),
    .tight     (tight),
    .win_vld   (win_vld),
    .win_lo    (win_lo),
    .win_hi    (win_hi)
  );

  flash_lock_window #(.BLK_W(BLK_W)) u_win (
    .blk      (req_blk),
    .glock    (glock),
    .win_vld  (win_vld),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .writable (writable)
  );

  flash_lock_resp u_resp (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .writable   (writable),
    .irq_clr    (irq_clr),
    .resp_valid (resp_valid),
    .resp_ok    (resp_ok),
    .irq_locked (irq_locked)
  );

endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int BLK_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             irq_clr,
  input logic             resp_valid,
  input logic             resp_ok,
  input logic             irq_locked,
  input logic             glock,
  input logic             tight,
  input logic             win_vld,
  input logic [BLK_W-1:0] win_lo,
  input logic [BLK_W-1:0] win_hi
);

  p_reset_open_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!glock && !tight && !irq_locked && !resp_valid));

  p_unlocked_ok_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !glock) |=> resp_ok);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  p_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !resp_ok));

  p_window_order_r5: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (win_lo < win_hi));

  p_tight_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    tight |=> tight);

  p_tight_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    tight |=> ($stable(glock) && $stable(win_vld) && $stable(win_lo) && $stable(win_hi)));

  p_refuse_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ok) |-> irq_locked);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_locked && !irq_clr) |=> irq_locked);

endmodule

bind flash_lock_mgr flash_lock_chk #(.BLK_W(BLK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .irq_clr    (irq_clr),
  .resp_valid (resp_valid),
  .resp_ok    (resp_ok),
  .irq_locked (irq_locked),
  .glock      (glock),
  .tight      (tight),
  .win_vld    (win_vld),
  .win_lo     (win_lo),
  .win_hi     (win_hi)
);

// File: tb/sim_flash_lock_mgr.sv
`timescale 1ns/1ps
module sim_flash_lock_mgr;

  localparam int BW = 4;
  localparam int NB = 1 << BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic [BW-1:0] cmd_blk = '0;
  logic          req_valid = 1'b0;
  logic [BW-1:0] req_blk = '0;
  logic          irq_clr = 1'b0;
  logic          resp_valid;
  logic          resp_ok;
  logic          irq_locked;

  always #4 clk = ~clk;

  flash_lock_mgr #(.BLK_W(BW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .req_valid(req_valid), .req_blk(req_blk), .irq_clr(irq_clr),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .irq_locked(irq_locked)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model of the requirements
  bit m_glock, m_tight, m_win, m_pend;
  int m_lo, m_hi, m_start;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int b);
    return !m_glock || (m_win && b >= m_lo && b <= m_hi);
  endfunction

  task automatic model_cmd(input int op, input int b);
    if (m_tight) return;
    case (op)
      'h10: begin m_start = b; m_pend = 1; end
      'h11: begin
        if (m_pend && m_start < b) begin m_lo = m_start; m_hi = b; m_win = 1; end
        m_pend = 0;
      end
      'h21: begin m_glock = 1; m_win = 0; end
      'h31: m_tight = 1;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_glock = 0; m_tight = 0; m_win = 0; m_pend = 0; m_lo = 0; m_hi = 0; m_start = 0;
  endtask

  task automatic cmd(input int op, input int b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'(op); cmd_blk = BW'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, b);
  endtask

  task automatic probe(input int b, input string req);
    bit e;
    e = exp_ok(b);
    @(negedge clk);
    req_valid = 1'b1; req_blk = BW'(b);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid === 1'b1 && resp_ok === e, req, {30'd0, resp_valid, resp_ok}, {30'd0, 1'b1, e});
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < NB; b++) probe(b, req);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(resp_valid === 1'b0, "R1", resp_valid, 0);
    chk(irq_locked === 1'b0, "R1", irq_locked, 0);
    sweep("R1");
    chk(irq_locked === 1'b0, "R1", irq_locked, 0);

    // R2: command and request in the same cycle, verdict uses the old state
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h21; cmd_blk = BW'(7);
    req_valid = 1'b1; req_blk = BW'(5);
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    chk(resp_valid === 1'b1 && resp_ok === 1'b1, "R2", resp_ok, 1);
    model_cmd('h21, 7);
    @(negedge clk);
    chk(resp_valid === 1'b0, "R2", resp_valid, 0);

    // R3: everything locked now, whatever address 0x21 carried
    sweep("R3");
    clear_irq();

    // R9: unknown opcodes change nothing
    cmd('h22, 3); cmd('h00, 0); cmd('h30, 9); cmd('h12, 1);
    sweep("R9");

    // R6: end without a pending start
    cmd('h11, 15);
    sweep("R6");

    // R4 / R5: exhaustive start/end pairs
    for (int s = 0; s < NB; s++) begin
      for (int e = 0; e < NB; e++) begin
        cmd('h21, s);
        cmd('h10, s);
        cmd('h11, e);
        if (s < e) sweep("R4"); else sweep("R5");
      end
    end

    // R5: an invalid pair keeps an existing window
    cmd('h21, 0); cmd('h10, 3); cmd('h11, 6);
    cmd('h10, 9); cmd('h11, 9);
    sweep("R5");
    cmd('h10, 12); cmd('h11, 2);
    sweep("R5");
    // R6: a second end after a consumed pair is ignored
    cmd('h11, 15);
    sweep("R6");
    // R3: lock-all discards the window, address ignored
    cmd('h21, 4);
    sweep("R3");
    clear_irq();

    // R8: sticky flag, clear, set-over-clear, writable request
    chk(irq_locked === 1'b0, "R8", irq_locked, 0);
    probe(2, "R8");
    chk(irq_locked === 1'b1, "R8", irq_locked, 1);
    repeat (3) @(negedge clk);
    chk(irq_locked === 1'b1, "R8", irq_locked, 1);
    clear_irq();
    chk(irq_locked === 1'b0, "R8", irq_locked, 0);
    @(negedge clk);
    req_valid = 1'b1; req_blk = BW'(9); irq_clr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; irq_clr = 1'b0;
    chk(irq_locked === 1'b1, "R8", irq_locked, 1);
    clear_irq();
    cmd('h10, 1); cmd('h11, 4);
    probe(3, "R8");
    chk(irq_locked === 1'b0, "R8", irq_locked, 0);

    // R7: tight freezes a partial window
    do_reset();
    cmd('h21, 0); cmd('h10, 2); cmd('h11, 5);
    cmd('h31, 0);
    cmd('h21, 11);
    cmd('h10, 0); cmd('h11, 15);
    sweep("R7");
    clear_irq();
    // R7: reset releases tight
    do_reset();
    sweep("R7");
    // R7: tight with no global lock keeps everything open
    cmd('h31, 0); cmd('h21, 6);
    sweep("R7");
    chk(irq_locked === 1'b0, "R7", irq_locked, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule